// File: doc/BRIEF.md
# Serial Configuration Memory Readout

This block models the read side of a serial configuration memory. It holds a byte array and sends it out one bit per rising clock edge to a device that is being configured. Bits leave each byte most significant first. A byte-address counter and a 3-bit bit counter track the position in the array. The serial output is driven only when the memory is selected and its output is enabled. At all other times the serial output is high-impedance, so several memories can share the data line.

A single pin carries both reset and output enable. In its reset state it clears both counters; in its enable state it lets the clock advance them and turns on the driver. A parameter selects the polarity of this pin. When the last bit of the array has been shifted out, the counters freeze at the final address. An active-low chain-enable output then hands the data line to the next memory in a daisy chain. It keeps doing so until the pin returns to its reset state.

A synchronous parallel load port fills the array for test. A write-protect input guards the lowest block of the array on that port.

Top module: `cfg_serial_rom`

## Requirements
- R1: While `ce_n` is low and the memory is enabled, each rising `clk` edge advances the read position by one bit. Within a byte, `sdo` presents bit 7 first and bit 0 last. The byte address steps by one after the bit-0 slot.
- R2: While the `rst_oe` pin is in its reset state, the bit counter and the address counter are held at zero, asynchronously to `clk`. After release, `sdo` presents bit 7 of byte 0.
- R3: `data_oe` is 1, and `sdo` is driven, only when all of the following hold: `ce_n` is low, the pin is in its enable state, and the end of the array has not been passed. Otherwise `data_oe` is 0 and `sdo` is high-impedance.
- R4: While `ce_n` is high, both counters hold their values (standby). After `ce_n` returns low, the stream resumes at the same bit.
- R5: After the clock edge that shifts out bit 0 of the last byte, an end flag is set. The counters then stop and do not wrap, whatever `ce_n` does, until the next reset.
- R6: `ceo_n` is 1 until the end flag is set. Once the flag is set, `ceo_n` equals `ce_n`. When the pin enters its reset state, `ceo_n` returns to 1 and stays 1 until the whole array has been read again.
- R7: With the default parameter `RST_ACTIVE_LOW = 1`, `rst_oe` = 0 is the reset state and `rst_oe` = 1 is the enable state. With `RST_ACTIVE_LOW = 0` the two states swap.
- R8: A load (`ld_en` = 1 at a rising `clk` edge) writes `ld_data` to byte `ld_addr`. The exception is when `ld_wp` = 1 and `ld_addr` is below `PROT_BYTES`: that write is discarded and the byte keeps its old value. With `ld_wp` = 0, every address is writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; also the clock of the load port |
| ce_n | input | 1 | Chip select, active low; high means standby |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_ACTIVE_LOW` |
| sdo | output | 1 | Serial data, high-impedance when not enabled |
| data_oe | output | 1 | High while `sdo` is driven |
| ceo_n | output | 1 | Chain enable toward the next memory, active low |
| ld_en | input | 1 | Load strobe for the parallel test port |
| ld_wp | input | 1 | Write protect for the lowest `PROT_BYTES` bytes |
| ld_addr | input | $clog2(DEPTH_BITS/8) | Byte address of a load |
| ld_data | input | 8 | Byte written by a load |

## Verification
The bench goes after the points where a shifting memory usually slips.

- **Byte boundaries.** An off-by-one there reorders bits or repeats bit 7, so the full-array readout shows a shifted pattern.
- **Standby gap.** A design that keeps counting while deselected skips bits after `ce_n` returns low.
- **Mid-stream reset.** If the reset fails to clear the counters, the stream does not restart at byte 0.
- **End of array.** A counter that wraps instead of holding drives stale data after the end, or releases `ceo_n` at the wrong moment.
- **Chain hand-off.** The bench toggles `ce_n` after the end, then resets and rereads partway, to catch a chain output that latches low or ignores the reset.
- **Write protect.** Protected bytes are rewritten while `ld_wp` is high. A leaky gate shows up as changed data in the lowest block.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_IW = $clog2(BYTE_W);

   // decoded view of the combined reset / output-enable pin
   typedef struct packed {
      logic clr;   // counters forced to zero
      logic en;    // counting and driving allowed
   } pin_dec_t;

   // bit select inside a byte for most-significant-first order
   function automatic logic [BIT_IW-1:0] msb_first(input logic [BIT_IW-1:0] slot);
      return BIT_IW'(BYTE_W - 1) - slot;
   endfunction

endpackage

// File: rtl/cfgrom_pin_dec.sv
module cfgrom_pin_dec #(
   parameter bit RST_ACTIVE_LOW = 1'b1
) (
   input  logic                  rst_oe,
   output cfgrom_pkg::pin_dec_t  dec
);

   generate
      if (RST_ACTIVE_LOW) begin : g_rst_low
         assign dec.clr = ~rst_oe;
         assign dec.en  =  rst_oe;
      end else begin : g_rst_high
         assign dec.clr =  rst_oe;
         assign dec.en  = ~rst_oe;
      end
   endgenerate

endmodule

// File: rtl/cfgrom_store.sv
module cfgrom_store #(
   parameter int NBYTES     = 4096,
   parameter int PROT_BYTES = 512,
   localparam int AW        = $clog2(NBYTES),
   localparam int DW        = cfgrom_pkg::BYTE_W
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_prot,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam logic [AW:0] PROT_LIM = (AW+1)'(PROT_BYTES);
   localparam logic [AW:0] LAST     = (AW+1)'(NBYTES - 1);

   logic [DW-1:0] mem [NBYTES];
   logic          blocked;
   logic          in_range;
   logic          wr_ok;

   generate
      if (PROT_BYTES == 0) begin : g_no_guard
         assign blocked = 1'b0;
      end else begin : g_guard
         assign blocked = wr_prot && ({1'b0, wr_addr} < PROT_LIM);
      end

      if ((1 << AW) == NBYTES) begin : g_pow2
         assign in_range = 1'b1;
      end else begin : g_npow2
         assign in_range = ({1'b0, wr_addr} <= LAST);
      end
   endgenerate

   assign wr_ok = wr_en && in_range && !blocked;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= wr_data;
   end

   // asynchronous read keeps the current bit available in the same cycle
   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq #(
   parameter int NBYTES = 4096,
   localparam int AW    = $clog2(NBYTES),
   localparam int BW    = cfgrom_pkg::BIT_IW
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic [BW-1:0] bit_idx,
   output logic          at_end
);

   localparam logic [AW-1:0] LAST_A = AW'(NBYTES - 1);
   localparam logic [BW-1:0] LAST_B = BW'(cfgrom_pkg::BYTE_W - 1);

   logic byte_done;
   logic adv;

   assign adv       = step && !at_end;
   assign byte_done = (bit_idx == LAST_B);

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         addr    <= '0;
         bit_idx <= '0;
         at_end  <= 1'b0;
      end else if (adv) begin
         bit_idx <= bit_idx + 1'b1;
         if (byte_done) begin
            if (addr == LAST_A) at_end <= 1'b1;
            else                addr   <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfgrom_chain.sv
module cfgrom_chain (
   input  logic ce_n,
   input  logic at_end,
   output logic ceo_n
);

   // before the end: next device held off; after it: pass the select through
   assign ceo_n = at_end ? ce_n : 1'b1;

endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom #(
   parameter int DEPTH_BITS     = 32768,
   parameter int PROT_BYTES     = 512,
   parameter bit RST_ACTIVE_LOW = 1'b1,
   localparam int NBYTES        = DEPTH_BITS / cfgrom_pkg::BYTE_W,
   localparam int AW            = $clog2(NBYTES)
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          rst_oe,
   output tri            sdo,
   output logic          data_oe,
   output logic          ceo_n,
   input  logic          ld_en,
   input  logic          ld_wp,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data
);

   import cfgrom_pkg::*;

   initial begin
      assert (DEPTH_BITS % BYTE_W == 0)
         else $error("DEPTH_BITS must be a whole number of bytes");
      assert (NBYTES >= 2)
         else $error("array needs at least two bytes");
      assert (PROT_BYTES >= 0 && PROT_BYTES <= NBYTES)
         else $error("protected block larger than array");
   end

   pin_dec_t          dec;
   logic              rst_act;
   logic              step;
   logic [AW-1:0]     addr_w;
   logic [BIT_IW-1:0] bit_w;
   logic              at_end_w;
   logic [BYTE_W-1:0] rd_byte;
   logic              cur_bit;

   cfgrom_pin_dec #(.RST_ACTIVE_LOW(RST_ACTIVE_LOW)) u_dec (
      .rst_oe (rst_oe),
      .dec    (dec)
   );

   assign rst_act = dec.clr;
   assign step    = !ce_n && dec.en;

   cfgrom_seq #(.NBYTES(NBYTES)) u_seq (
      .clk     (clk),
      .clr     (rst_act),
      .step    (step),
      .addr    (addr_w),
      .bit_idx (bit_w),
      .at_end  (at_end_w)
   );

   cfgrom_store #(.NBYTES(NBYTES), .PROT_BYTES(PROT_BYTES)) u_store (
      .clk     (clk),
      .wr_en   (ld_en),
      .wr_prot (ld_wp),
      .wr_addr (ld_addr),
      .wr_data (ld_data),
      .rd_addr (addr_w),
      .rd_data (rd_byte)
   );

   cfgrom_chain u_chain (
      .ce_n   (ce_n),
      .at_end (at_end_w),
      .ceo_n  (ceo_n)
   );

   assign cur_bit = rd_byte[msb_first(bit_w)];
   assign data_oe = step && !at_end_w;
   assign sdo     = data_oe ? cur_bit : 1'bz;

endmodule

// File: rtl/cfgrom_chk.sv
module cfgrom_chk #(
   parameter int NBYTES = 4096,
   localparam int AW    = $clog2(NBYTES)
) (
   input logic          clk,
   input logic          rst_act,
   input logic          ce_n,
   input logic          data_oe,
   input logic          ceo_n,
   input logic [AW-1:0] addr,
   input logic [2:0]    bit_idx,
   input logic          at_end
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst_act |-> (addr == '0 && bit_idx == 3'd0 && !at_end));                          // R2

   AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (rst_act)
      (!ce_n && !at_end) |=> (bit_idx == $past(bit_idx) + 3'd1));                       // R1

   AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (rst_act)
      (ce_n || at_end) |-> !data_oe);                                                   // R3

   AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (rst_act)
      ce_n |=> ($stable(addr) && $stable(bit_idx)));                                    // R4

   AST_END_STICKY: assert property (@(posedge clk) disable iff (rst_act)
      at_end |=> (at_end && $stable(addr)));                                            // R5

   AST_CHAIN_FOLLOW: assert property (@(posedge clk) disable iff (rst_act)
      at_end |-> (ceo_n == ce_n));                                                      // R6

   AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst_act)
      !at_end |-> ceo_n);                                                               // R6

endmodule

bind cfg_serial_rom cfgrom_chk #(.NBYTES(NBYTES)) u_chk (
   .clk     (clk),
   .rst_act (rst_act),
   .ce_n    (ce_n),
   .data_oe (data_oe),
   .ceo_n   (ceo_n),
   .addr    (addr_w),
   .bit_idx (bit_w),
   .at_end  (at_end_w)
);

// File: tb/tb_cfg_serial_rom.sv
module tb_cfg_serial_rom;

   localparam int DEPTH_BITS = 32768;
   localparam int PROT_BYTES = 512;
   localparam int NBYTES     = DEPTH_BITS / 8;
   localparam int AW         = $clog2(NBYTES);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          ce_n    = 1'b1;
   logic          rst_oe  = 1'b1;
   logic          ld_en   = 1'b0;
   logic          ld_wp   = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [7:0]    ld_data = '0;
   wire           sdo;
   logic          data_oe;
   logic          ceo_n;

   cfg_serial_rom #(.DEPTH_BITS(DEPTH_BITS), .PROT_BYTES(PROT_BYTES)) dut (
      .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe), .sdo(sdo), .data_oe(data_oe),
      .ceo_n(ceo_n), .ld_en(ld_en), .ld_wp(ld_wp), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   // reference model
   logic [7:0] ref_mem [NBYTES];
   int pos = 0;
   int checks = 0;
   int fails = 0;
   bit cmp_on = 1'b0;
   bit done_flag = 1'b0;

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) ^ (i >> 4));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   // R7: rst_oe low is the reset state with the default polarity
   always @(posedge clk) begin
      if (!rst_oe) pos = 0;
      else if (!ce_n && pos < DEPTH_BITS) pos = pos + 1;
      if (ld_en && !(ld_wp && int'(ld_addr) < PROT_BYTES)) ref_mem[ld_addr] <= ld_data;
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         bit exp_oe;
         bit exp_ceo;
         if (!rst_oe) pos = 0;
         exp_oe  = rst_oe && !ce_n && (pos < DEPTH_BITS);
         exp_ceo = (pos == DEPTH_BITS) ? ce_n : 1'b1;
         chk(data_oe === exp_oe, "R3", "data_oe", int'(data_oe), int'(exp_oe));
         if (exp_oe) begin
            logic eb;
            eb = ref_mem[pos / 8][7 - (pos % 8)];
            // protected block content checks R8, the rest R1
            chk(sdo === eb, (pos / 8 < PROT_BYTES) ? "R8" : "R1", "sdo", int'(sdo), int'(eb));
         end
         chk(ceo_n === exp_ceo, "R6", "ceo_n", int'(ceo_n), int'(exp_ceo));
      end
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic snap;
      #5 rst_oe = 1'b0;
      cyc(1);
      // load pattern with protection off (R8)
      for (int i = 0; i < NBYTES; i++) begin
         ld_en = 1'b1; ld_addr = AW'(i); ld_data = pat(i);
         cyc(1);
      end
      // overwrite with protection on: lowest block must keep the first pattern (R8)
      ld_wp = 1'b1;
      for (int i = 0; i < NBYTES; i++) begin
         ld_en = 1'b1; ld_addr = AW'(i); ld_data = ~pat(i);
         cyc(1);
      end
      ld_en = 1'b0; ld_wp = 1'b0;
      cmp_on = 1'b1;

      // reset state (R2, R7)
      ce_n = 1'b0;
      @(negedge clk);
      chk(data_oe === 1'b0, "R7", "data_oe in reset", int'(data_oe), 0);
      chk(ceo_n === 1'b1, "R2", "ceo_n in reset", int'(ceo_n), 1);
      cyc(1);
      rst_oe = 1'b1;
      @(negedge clk);
      chk(data_oe === 1'b1, "R7", "data_oe enabled", int'(data_oe), 1);
      chk(sdo === pat(0)[7], "R2", "first bit", int'(sdo), int'(pat(0)[7]));
      cyc(101);

      // standby gap (R4)
      @(negedge clk);
      snap = sdo;
      cyc(1);
      ce_n = 1'b1;
      cyc(20);
      ce_n = 1'b0;
      @(negedge clk);
      chk(sdo === snap, "R4", "resume bit", int'(sdo), int'(snap));
      cyc(300);

      // mid-stream reset (R2)
      rst_oe = 1'b0;
      cyc(3);
      rst_oe = 1'b1;
      @(negedge clk);
      chk(sdo === pat(0)[7], "R2", "restart bit", int'(sdo), int'(pat(0)[7]));

      // full readout to the end (R1, R5)
      cyc(DEPTH_BITS + 3);
      @(negedge clk);
      chk(ceo_n === 1'b0, "R5", "ceo_n at end", int'(ceo_n), 0);
      chk(data_oe === 1'b0, "R5", "driver off at end", int'(data_oe), 0);
      cyc(50);
      chk(ceo_n === 1'b0, "R5", "end held", int'(ceo_n), 0);

      // hand-off: follow ce_n, then high after reset (R6)
      ce_n = 1'b1;
      cyc(2);
      chk(ceo_n === 1'b1, "R6", "ceo_n follows ce_n high", int'(ceo_n), 1);
      ce_n = 1'b0;
      @(negedge clk);
      chk(ceo_n === 1'b0, "R6", "ceo_n follows ce_n low", int'(ceo_n), 0);
      cyc(1);
      rst_oe = 1'b0;
      cyc(2);
      rst_oe = 1'b1;
      cyc(40);
      chk(ceo_n === 1'b1, "R6", "ceo_n high after reread start", int'(ceo_n), 1);

      cmp_on = 1'b0;
      ce_n = 1'b1;
      cyc(2);
      finish_run();
   end

endmodule